// File: doc/BRIEF.md
# Bitmap Font Glyph Blitter

The blitter draws a zero-terminated string of 8-bit character codes into a framebuffer that is 64 pixels wide, with one RGB565 word per pixel. A start pulse captures a pixel origin and a foreground and background colour. The block then takes character codes one at a time over a valid/ready handshake. For each glyph it reads eleven row bytes from a font memory and writes one framebuffer word for every bit of every row.

Glyphs sit side by side, 8 pixels apart, on the row given by the origin. Each row byte is expanded most significant bit first. A set bit produces the foreground colour and a clear bit the background colour, so all 88 cells of a glyph overwrite whatever was there before. The font memory returns data one cycle after a read, and the blitter waits for that byte before it writes the row. Address arithmetic wraps at 12 bits and is never clipped.

Top module: `glyph_blitter`

## Requirements
- R1: While reset is held, and until a start is accepted, `busy`, `chr_ready`, `font_rd_en` and `fb_we` are all low.
- R2: A start seen while idle raises `busy` on the next cycle. `chr_ready` is high only while the block waits for the next code. `chr_valid` has no effect while `chr_ready` is low, and exactly one code is taken per handshake.
- R3: For an accepted code c, the font is read eleven times, once per glyph row i = 0..10 in ascending order, at address c*11 + i.
- R4: The eight framebuffer writes of a row begin two cycles after that row's read is issued: read cycle, one wait cycle, then eight consecutive write cycles.
- R5: Write j of a row (j = 0..7) takes bit 7-j of the row byte. A 1 writes the foreground colour and a 0 writes the background colour, each a full 16-bit word.
- R6: For character index k (0 for the first code after start), row i and bit j, the write address is (x + j) + 8*k + (y + i)*64.
- R7: Every glyph produces exactly 88 writes, with `fb_we` high on exactly those cycles.
- R8: A code of zero ends the string. It is accepted, causes no read and no write, and `busy` is low on the next cycle.
- R9: A start pulse while `busy` is high is ignored, and the output sequence continues unchanged.
- R10: All address arithmetic is truncated to 12 bits, so addresses past 4095 wrap to the low end.
- R11: The origin and both colours are captured only when a start is accepted. Changes to them during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a string; captures origin and colours |
| org_x | input | 12 | Pixel column of the first glyph |
| org_y | input | 12 | Pixel row of the glyph tops |
| fg_color | input | 16 | RGB565 colour for set bits |
| bg_color | input | 16 | RGB565 colour for clear bits |
| chr_valid | input | 1 | Character code offered |
| chr_code | input | 8 | Character code; zero terminates |
| chr_ready | output | 1 | Blitter takes a code this cycle if valid |
| busy | output | 1 | A string is being drawn |
| font_rd_en | output | 1 | Font read strobe |
| font_rd_addr | output | 12 | Font byte address |
| font_rd_data | input | 8 | Font row byte, valid one cycle after the read |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | 12 | Framebuffer word address |
| fb_data | output | 16 | RGB565 pixel word |

## Verification
The assertions check several properties on every cycle:
- the read-to-write spacing of each row and the run of exactly eight writes;
- the step-by-one address progression inside a row;
- the idle state after a zero code;
- that `busy` is held through stray start pulses;
- that the captured colours and origin stay stable.

Only the bench scenarios can show the following:
- the absolute font and framebuffer addresses, including wrap-around;
- the bit-to-colour mapping against a known font image;
- that colour and origin changes and stray handshakes during a run have no effect;
- the handshake stalls between glyphs.

The bench compares every output against its own cycle-by-cycle reference model.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WAIT,
    ST_DRAW
  } blit_state_e;
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CODE_W  = 8,
  parameter int GLYPH_W = 8,
  parameter int GLYPH_H = 11,
  localparam int COL_W  = $clog2(GLYPH_W),
  localparam int ROW_W  = $clog2(GLYPH_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chr_valid,
  input  logic [CODE_W-1:0] chr_code,
  output logic              chr_ready,
  output logic              busy,
  output logic              font_rd_en,
  output logic              launch,
  output logic              capture,
  output logic              draw_en,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic [ADDR_W-1:0] chr_q,
  output logic [CODE_W-1:0] code_q
);
  blit_state_e       state_q, state_d;
  logic [ROW_W-1:0]  row_d;
  logic [COL_W-1:0]  col_d;
  logic [ADDR_W-1:0] chr_d;
  logic [CODE_W-1:0] code_d;
  logic              take;
  logic              last_col, last_row;

  assign take     = (state_q == ST_FETCH) && chr_valid;
  assign last_col = (col_q == COL_W'(GLYPH_W - 1));
  assign last_row = (row_q == ROW_W'(GLYPH_H - 1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    col_d   = col_q;
    chr_d   = chr_q;
    code_d  = code_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_FETCH;
        chr_d   = '0;
      end
      ST_FETCH: if (take) begin
        if (chr_code == '0) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_READ;
          code_d  = chr_code;
          row_d   = '0;
        end
      end
      ST_READ: state_d = ST_WAIT;
      ST_WAIT: begin
        state_d = ST_DRAW;
        col_d   = '0;
      end
      ST_DRAW: begin
        col_d = col_q + 1'b1;
        if (last_col) begin
          if (last_row) begin
            state_d = ST_FETCH;
            chr_d   = chr_q + 1'b1;
          end else begin
            state_d = ST_READ;
            row_d   = row_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      chr_q   <= '0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      col_q   <= col_d;
      chr_q   <= chr_d;
      if (take) code_q <= code_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign chr_ready  = (state_q == ST_FETCH);
  assign font_rd_en = (state_q == ST_READ);
  assign capture    = (state_q == ST_WAIT);
  assign draw_en    = (state_q == ST_DRAW);
  assign launch     = (state_q == ST_IDLE) && start;

  // R4: a write burst always starts two cycles after a font read
  p_read_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(draw_en) |-> $past(font_rd_en, 2));
  // R4: nothing is written in the cycle that follows a read
  p_read_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    font_rd_en |=> (!draw_en && !font_rd_en));
  // R7: a burst ends after its eighth write
  p_burst_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_en && last_col) |=> !draw_en);
  // R3: rows are read in range
  p_row_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    font_rd_en |-> (row_q < ROW_W'(GLYPH_H)));
  // R8: a zero code ends the run
  p_zero_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_ready && chr_valid && chr_code == '0) |=> !busy);
  // R9: a start during a run does not restart or stop it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(chr_ready && chr_valid && chr_code == '0)) |=> busy);
endmodule

// File: rtl/blit_font_addr.sv
module blit_font_addr #(
  parameter int CODE_W  = 8,
  parameter int FONT_AW = 12,
  parameter int GLYPH_H = 11,
  localparam int ROW_W  = $clog2(GLYPH_H)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [CODE_W-1:0]  code,
  input  logic [ROW_W-1:0]   row,
  output logic [FONT_AW-1:0] rd_addr
);
  logic [FONT_AW-1:0] base;

  assign base    = FONT_AW'(code) * FONT_AW'(GLYPH_H);
  assign rd_addr = base + FONT_AW'(row);

  // R3: consecutive reads within a glyph advance by one row
  p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && row != '0 && $past(code) == code && $past(rd_en, 10))
      |-> rd_addr == $past(rd_addr, 10) + 1'b1);
endmodule

// File: rtl/blit_pixel_addr.sv
module blit_pixel_addr #(
  parameter int ADDR_W      = 12,
  parameter int GLYPH_W     = 8,
  parameter int GLYPH_H     = 11,
  parameter int STRIDE_LOG2 = 6,
  localparam int COL_W      = $clog2(GLYPH_W),
  localparam int ROW_W      = $clog2(GLYPH_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              draw_en,
  input  logic [ADDR_W-1:0] org_x,
  input  logic [ADDR_W-1:0] org_y,
  input  logic [ADDR_W-1:0] chr_idx,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output logic [ADDR_W-1:0] fb_addr
);
  logic [ADDR_W-1:0] ox_q, oy_q;
  logic [ADDR_W-1:0] col_off, chr_off, line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ox_q <= '0;
      oy_q <= '0;
    end else if (launch) begin
      ox_q <= org_x;
      oy_q <= org_y;
    end
  end

  assign col_off = ox_q + ADDR_W'(col);
  assign chr_off = chr_idx << COL_W;
  assign line    = (oy_q + ADDR_W'(row)) << STRIDE_LOG2;
  assign fb_addr = col_off + chr_off + line;

  // R6/R10: within a burst the address advances by one, wrapping at 12 bits
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_en && $past(draw_en)) |-> fb_addr == $past(fb_addr) + 1'b1);
  // R11: the origin is held for the whole run
  p_origin_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> ($stable(ox_q) && $stable(oy_q)));
endmodule

// File: rtl/blit_row_shift.sv
module blit_row_shift #(
  parameter int COLOR_W = 16,
  parameter int GLYPH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               capture,
  input  logic               draw_en,
  input  logic [COLOR_W-1:0] fg_color,
  input  logic [COLOR_W-1:0] bg_color,
  input  logic [GLYPH_W-1:0] row_byte,
  output logic [COLOR_W-1:0] pix_data
);
  logic [COLOR_W-1:0] fg_q, bg_q;
  logic [GLYPH_W-1:0] sh_q, sh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg_q <= '0;
      bg_q <= '0;
    end else if (launch) begin
      fg_q <= fg_color;
      bg_q <= bg_color;
    end
  end

  always_comb begin
    sh_d = sh_q;
    if (capture)      sh_d = row_byte;
    else if (draw_en) sh_d = {sh_q[GLYPH_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (capture || draw_en) sh_q <= sh_d;
  end

  assign pix_data = sh_q[GLYPH_W-1] ? fg_q : bg_q;

  // R11: colours only change when a start is accepted
  p_color_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> ($stable(fg_q) && $stable(bg_q)));
  // R5: the shifter is refilled only between bursts
  p_load_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> draw_en);
endmodule

// File: rtl/glyph_blitter.sv
module glyph_blitter #(
  parameter int ADDR_W      = 12,
  parameter int FONT_AW     = 12,
  parameter int CODE_W      = 8,
  parameter int COLOR_W     = 16,
  parameter int GLYPH_W     = 8,
  parameter int GLYPH_H     = 11,
  parameter int STRIDE_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  org_x,
  input  logic [ADDR_W-1:0]  org_y,
  input  logic [COLOR_W-1:0] fg_color,
  input  logic [COLOR_W-1:0] bg_color,
  input  logic               chr_valid,
  input  logic [CODE_W-1:0]  chr_code,
  output logic               chr_ready,
  output logic               busy,
  output logic               font_rd_en,
  output logic [FONT_AW-1:0] font_rd_addr,
  input  logic [GLYPH_W-1:0] font_rd_data,
  output logic               fb_we,
  output logic [ADDR_W-1:0]  fb_addr,
  output logic [COLOR_W-1:0] fb_data
);
  localparam int COL_W = $clog2(GLYPH_W);
  localparam int ROW_W = $clog2(GLYPH_H);

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              launch, capture, draw_en;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [ADDR_W-1:0] chr_idx;
  logic [CODE_W-1:0] code;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  blit_ctrl #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .GLYPH_W(GLYPH_W), .GLYPH_H(GLYPH_H)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .start(start), .chr_valid(chr_valid),
    .chr_code(chr_code), .chr_ready(chr_ready), .busy(busy),
    .font_rd_en(font_rd_en), .launch(launch), .capture(capture),
    .draw_en(draw_en), .row_q(row), .col_q(col), .chr_q(chr_idx),
    .code_q(code)
  );

  blit_font_addr #(
    .CODE_W(CODE_W), .FONT_AW(FONT_AW), .GLYPH_H(GLYPH_H)
  ) u_font_addr (
    .clk(clk), .rst_n(rst_ni), .rd_en(font_rd_en), .code(code), .row(row),
    .rd_addr(font_rd_addr)
  );

  blit_pixel_addr #(
    .ADDR_W(ADDR_W), .GLYPH_W(GLYPH_W), .GLYPH_H(GLYPH_H),
    .STRIDE_LOG2(STRIDE_LOG2)
  ) u_pixel_addr (
    .clk(clk), .rst_n(rst_ni), .launch(launch), .draw_en(draw_en),
    .org_x(org_x), .org_y(org_y), .chr_idx(chr_idx), .row(row), .col(col),
    .fb_addr(fb_addr)
  );

  blit_row_shift #(
    .COLOR_W(COLOR_W), .GLYPH_W(GLYPH_W)
  ) u_row_shift (
    .clk(clk), .rst_n(rst_ni), .launch(launch), .capture(capture),
    .draw_en(draw_en), .fg_color(fg_color), .bg_color(bg_color),
    .row_byte(font_rd_data), .pix_data(fb_data)
  );

  assign fb_we = draw_en;

  // R7: writes only happen inside a run
  p_write_in_run_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    fb_we |-> busy);
  // R1: nothing is issued while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (!fb_we && !font_rd_en && !chr_ready));
endmodule

// File: tb/glyph_blitter_test.sv
module glyph_blitter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [11:0] org_x, org_y;
  logic [15:0] fg_color, bg_color;
  logic        chr_valid;
  logic [7:0]  chr_code;
  logic        chr_ready, busy, font_rd_en, fb_we;
  logic [11:0] font_rd_addr, fb_addr;
  logic [7:0]  font_rd_data;
  logic [15:0] fb_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  glyph_blitter uut (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .fg_color(fg_color), .bg_color(bg_color), .chr_valid(chr_valid),
    .chr_code(chr_code), .chr_ready(chr_ready), .busy(busy),
    .font_rd_en(font_rd_en), .font_rd_addr(font_rd_addr),
    .font_rd_data(font_rd_data), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_data(fb_data)
  );

  // font image known to the bench
  function automatic logic [7:0] font_fn(input int a);
    return 8'((a * 29) ^ (a >> 2) ^ 8'h5A);
  endfunction

  always_ff @(posedge clk) begin
    if (font_rd_en) font_rd_data <= font_fn(int'(font_rd_addr));
  end

  typedef struct {
    bit          start;
    bit          valid;
    logic [7:0]  code;
    logic [15:0] fg, bg;
    logic [11:0] ox, oy;
    bit          e_busy, e_ready, e_rd, e_we;
    logic [11:0] e_rd_addr, e_addr;
    logic [15:0] e_data;
  } cyc_t;

  cyc_t   sched[$];
  int     str_q[$];

  function automatic cyc_t idle_rec();
    cyc_t r;
    r.start = 0; r.valid = 0; r.code = 8'h41;
    r.fg = 16'h0; r.bg = 16'h0; r.ox = 12'h0; r.oy = 12'h0;
    r.e_busy = 0; r.e_ready = 0; r.e_rd = 0; r.e_we = 0;
    r.e_rd_addr = 0; r.e_addr = 0; r.e_data = 0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: builds the exact cycle schedule of one string
  task automatic build_run(input int ox, input int oy, input int fg,
                           input int bg, input int gap, input bit perturb);
    cyc_t r;
    int   k;
    r = idle_rec();
    r.start = 1; r.ox = 12'(ox); r.oy = 12'(oy); r.fg = 16'(fg); r.bg = 16'(bg);
    sched.push_back(r);
    str_q.push_back(0);
    k = 0;
    foreach (str_q[n]) begin
      int c = str_q[n];
      for (int g = 0; g < gap; g++) begin
        r = idle_rec(); r.e_busy = 1; r.e_ready = 1;
        if (perturb) begin  // R9, R11: stray start and new origin/colours
          r.start = 1; r.fg = 16'hFFFF; r.bg = 16'h1234; r.ox = 12'h777; r.oy = 12'h3;
        end
        sched.push_back(r);
      end
      r = idle_rec(); r.e_busy = 1; r.e_ready = 1; r.valid = 1; r.code = 8'(c);
      sched.push_back(r);
      if (c == 0) break;
      for (int i = 0; i < 11; i++) begin
        int rb = int'(font_fn(c * 11 + i));
        r = idle_rec(); r.e_busy = 1; r.e_rd = 1; r.e_rd_addr = 12'(c * 11 + i);
        if (perturb) begin r.valid = 1; r.code = 8'h00; r.start = 1; end  // R2
        sched.push_back(r);
        r = idle_rec(); r.e_busy = 1;
        if (perturb) begin r.valid = 1; r.code = 8'h7E; end
        sched.push_back(r);
        for (int j = 0; j < 8; j++) begin
          r = idle_rec(); r.e_busy = 1; r.e_we = 1;
          r.e_addr = 12'((ox + j) + 8 * k + (oy + i) * 64);   // R6, R10
          r.e_data = ((rb >> (7 - j)) & 1) != 0 ? 16'(fg) : 16'(bg);  // R5
          if (perturb) begin r.start = 1; r.fg = 16'hAAAA; r.valid = 1; r.code = 8'h00; end
          sched.push_back(r);
        end
      end
      k++;
    end
    sched.push_back(idle_rec());  // R8: busy drops after the zero code
    sched.push_back(idle_rec());
    str_q.delete();
  endtask

  task automatic run_sched();
    while (sched.size() > 0) begin
      cyc_t r = sched.pop_front();
      @(negedge clk);
      chk(busy == r.e_busy, "R2/R8 busy", 32'(busy), 32'(r.e_busy));
      chk(chr_ready == r.e_ready, "R2 chr_ready", 32'(chr_ready), 32'(r.e_ready));
      chk(font_rd_en == r.e_rd, "R4 font_rd_en", 32'(font_rd_en), 32'(r.e_rd));
      if (r.e_rd)
        chk(font_rd_addr == r.e_rd_addr, "R3 font_rd_addr", 32'(font_rd_addr), 32'(r.e_rd_addr));
      chk(fb_we == r.e_we, "R7 fb_we", 32'(fb_we), 32'(r.e_we));
      if (r.e_we) begin
        chk(fb_addr == r.e_addr, "R6 fb_addr", 32'(fb_addr), 32'(r.e_addr));
        chk(fb_data == r.e_data, "R5 fb_data", 32'(fb_data), 32'(r.e_data));
      end
      start = r.start; chr_valid = r.valid; chr_code = r.code;
      fg_color = r.fg; bg_color = r.bg; org_x = r.ox; org_y = r.oy;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc_t r;
    rst_n = 0; start = 0; chr_valid = 0; chr_code = 0;
    org_x = 0; org_y = 0; fg_color = 0; bg_color = 0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset
    chk(!busy && !chr_ready && !font_rd_en && !fb_we, "R1 reset outputs",
        {busy, chr_ready, font_rd_en, fb_we}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !fb_we, "R1 idle after release", {busy, fb_we}, 0);

    // R2: valid while idle without start is ignored
    for (int n = 0; n < 3; n++) begin
      r = idle_rec(); r.valid = 1; r.code = 8'h33; sched.push_back(r);
    end
    sched.push_back(idle_rec());
    run_sched();

    // basic two-character string
    str_q = '{8'h41, 8'h42};
    build_run(3, 5, 16'hF800, 16'h001F, 0, 0);
    run_sched();

    // R8: empty string draws nothing
    build_run(10, 10, 16'hFFFF, 16'h0000, 0, 0);
    run_sched();

    // R9, R11, R2: stalls, stray starts and colour/origin changes mid-run
    str_q = '{8'h01, 8'hFF, 8'h7A};
    build_run(0, 0, 16'h07E0, 16'h8410, 3, 1);
    run_sched();

    // R10: addresses wrap past 4095
    str_q = '{8'h55, 8'hAA};
    build_run(4090, 62, 16'h1234, 16'hFEDC, 1, 0);
    run_sched();

    finish_run();
  end
endmodule